// File: doc/BRIEF.md
# Overlap-Shared Miss Cost Accumulator

This block sits beside the miss-tracking register file of a cache and measures how much processor stall each outstanding miss is responsible for. Every clock cycle is split evenly among the demand misses in flight at the start of that cycle. An isolated miss is charged the full cycle. A miss that overlaps with others is charged only its share. Misses flagged as prefetches are tracked but never charged.

The miss-tracking control chooses the slot for each new miss and presents its index, line address and prefetch flag. It later names the slot that retires. On each valid retirement the block emits a one-cycle result carrying the line address and a 3-bit cost class. A replacement policy uses that class to prefer keeping blocks whose misses are expensive.

Top module: `mlp_cost_acc`

## Requirements
- R1: After synchronous reset every slot is empty and `rel_valid` is 0. A release of any slot before its first allocation produces no pulse.
- R2: A demand miss that is the only outstanding demand miss gains exactly 1.0 cycle per cycle, which is 256 units in a fixed-point cost with 8 fraction bits.
- R3: With N valid demand slots at the start of a cycle, each of them gains floor(256/N) units in that cycle. A slot allocated in a cycle is not counted in that cycle and starts gaining in the next one.
- R4: Prefetch slots (`alloc_prefetch`=1) do not count toward N, gain nothing, and report cost class 0.
- R5: Releasing a valid slot raises `rel_valid` for exactly the following cycle, together with that slot's line address and cost class. The cost includes the share for the release cycle. Releasing an empty slot raises no pulse.
- R6: The cost class is floor(integer cycles / 60), saturated at 7. The 18-bit accumulator saturates at its all-ones value and does not wrap.
- R7: Allocation clears the slot's cost to zero. This holds even when the slot held an earlier miss.
- R8: An allocation and a release in the same cycle both take effect, and N for that cycle comes from the slots valid at its start. When both name the same slot, the pulse reports the old miss and the slot restarts empty of cost with the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_en | input | 1 | Record a new miss this cycle |
| alloc_idx | input | 5 | Slot chosen for the new miss |
| alloc_addr | input | 26 | Line address of the new miss |
| alloc_prefetch | input | 1 | 1 = prefetch miss (uncharged), 0 = demand miss |
| free_en | input | 1 | Retire a slot this cycle |
| free_idx | input | 5 | Slot being retired |
| rel_valid | output | 1 | One-cycle result strobe |
| rel_addr | output | 26 | Line address of the retired miss |
| rel_cost | output | 3 | Quantized cost class of the retired miss |

## Verification
The two functions that can coincide are allocation and release. A release that meets an allocation must still divide the cycle by the start-of-cycle count. When both name one slot, the old miss must be reported while the new one starts at zero. The bench provokes this with a directed swap on one slot, with simultaneous allocation and release on different slots, and with several thousand random cycles in which both requests are frequently asserted together. A behavioural model judges each cycle by applying the release decision and all cost charges to the pre-cycle state before it updates the slot contents.

// File: rtl/mlp_cost_pkg.sv
package mlp_cost_pkg;
  localparam int DEF_ENTRIES = 32;
  localparam int DEF_ADDR_W  = 26;
  localparam int DEF_FRAC_W  = 8;
  localparam int DEF_INT_W   = 10;
  localparam int DEF_BIN_CYC = 60;
  localparam int DEF_QW      = 3;

  typedef enum logic {MISS_DEMAND = 1'b0, MISS_PREFETCH = 1'b1} miss_kind_e;
endpackage

// File: rtl/mlp_demand_count.sv
module mlp_demand_count #(
  parameter int ENTRIES = 32,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] demand_i,
  output logic [CNT_W-1:0]   n_o
);
  always_comb begin
    n_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      n_o = n_o + CNT_W'(valid_i[i] & demand_i[i]);
    end
  end
endmodule

// File: rtl/mlp_recip_lut.sv
module mlp_recip_lut #(
  parameter int ENTRIES = 32,
  parameter int FRAC_W  = 8,
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int SW     = FRAC_W + 1
) (
  input  logic [CNT_W-1:0] n_i,
  output logic [SW-1:0]    share_o
);
  logic [SW-1:0] tbl [ENTRIES+1];

  for (genvar k = 0; k <= ENTRIES; k++) begin : g_tbl
    if (k == 0) begin : g_zero
      assign tbl[k] = '0;
    end else begin : g_div
      assign tbl[k] = SW'((1 << FRAC_W) / k);
    end
  end

  always_comb begin
    share_o = '0;
    if (int'(n_i) <= ENTRIES) share_o = tbl[n_i];
  end
endmodule

// File: rtl/mlp_cost_entry.sv
module mlp_cost_entry #(
  parameter int CW = 18,
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_i,
  input  logic          alloc_demand_i,
  input  logic          free_i,
  input  logic [SW-1:0] share_i,
  output logic          valid_o,
  output logic          demand_o,
  output logic [CW-1:0] cost_o
);
  logic          valid_q, demand_q;
  logic [CW-1:0] cost_q;
  logic [CW:0]   sum;
  logic [CW-1:0] cost_sat;

  assign sum      = {1'b0, cost_q} + (CW+1)'(share_i);
  assign cost_sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      demand_q <= 1'b0;
      cost_q   <= '0;
    end else if (alloc_i) begin
      valid_q  <= 1'b1;
      demand_q <= alloc_demand_i;
      cost_q   <= '0;
    end else begin
      if (free_i) valid_q <= 1'b0;
      if (valid_q && demand_q) cost_q <= cost_sat;
    end
  end

  assign valid_o  = valid_q;
  assign demand_o = demand_q;
  assign cost_o   = cost_q;

  // R7
  alloc_clears_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_i |=> (valid_q && cost_q == '0));

  // R4
  prefetch_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !demand_q) |-> cost_q == '0);

  // R6
  cost_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !alloc_i) |=> cost_q >= $past(cost_q));
endmodule

// File: rtl/mlp_cost_quant.sv
module mlp_cost_quant #(
  parameter int CW      = 18,
  parameter int SW      = 9,
  parameter int FRAC_W  = 8,
  parameter int BIN_CYC = 60,
  parameter int QW      = 3,
  localparam int LEVELS = 1 << QW,
  localparam int IW     = CW - FRAC_W
) (
  input  logic [CW-1:0] cost_i,
  input  logic [SW-1:0] share_i,
  input  logic          add_i,
  output logic [QW-1:0] q_o
);
  logic [CW:0]        sum;
  logic [CW-1:0]      total;
  logic [IW-1:0]      whole;
  logic [LEVELS-2:0]  ge;

  assign sum   = {1'b0, cost_i} + (add_i ? (CW+1)'(share_i) : '0);
  assign total = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
  assign whole = total[CW-1:FRAC_W];

  for (genvar k = 1; k < LEVELS; k++) begin : g_thr
    assign ge[k-1] = 32'(whole) >= 32'(k * BIN_CYC);
  end

  always_comb begin
    q_o = '0;
    for (int k = 0; k < LEVELS - 1; k++) q_o = q_o + QW'(ge[k]);
  end
endmodule

// File: rtl/mlp_addr_ram.sv
module mlp_addr_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 26,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mlp_cost_acc.sv
module mlp_cost_acc
  import mlp_cost_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int FRAC_W  = DEF_FRAC_W,
  parameter int INT_W   = DEF_INT_W,
  parameter int BIN_CYC = DEF_BIN_CYC,
  parameter int QW      = DEF_QW,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1),
  localparam int CW     = INT_W + FRAC_W,
  localparam int SW     = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_prefetch,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  output logic              rel_valid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic [QW-1:0]     rel_cost
);
  logic [ENTRIES-1:0] valid_vec, demand_vec;
  logic [CW-1:0]      cost_arr [ENTRIES];
  logic [CNT_W-1:0]   n_demand;
  logic [SW-1:0]      share;
  logic [QW-1:0]      q_now;
  logic               hit_free;
  logic               rel_valid_q;
  logic [QW-1:0]      rel_cost_q;
  miss_kind_e         kind;

  assign kind = alloc_prefetch ? MISS_PREFETCH : MISS_DEMAND;

  mlp_demand_count #(.ENTRIES(ENTRIES)) u_count (
    .valid_i(valid_vec), .demand_i(demand_vec), .n_o(n_demand));

  mlp_recip_lut #(.ENTRIES(ENTRIES), .FRAC_W(FRAC_W)) u_recip (
    .n_i(n_demand), .share_o(share));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    mlp_cost_entry #(.CW(CW), .SW(SW)) u_ent (
      .clk(clk), .rst(rst),
      .alloc_i(alloc_en && alloc_idx == IDX_W'(i)),
      .alloc_demand_i(kind == MISS_DEMAND),
      .free_i(free_en && free_idx == IDX_W'(i)),
      .share_i(share),
      .valid_o(valid_vec[i]),
      .demand_o(demand_vec[i]),
      .cost_o(cost_arr[i]));
  end

  assign hit_free = free_en && valid_vec[free_idx];

  mlp_cost_quant #(.CW(CW), .SW(SW), .FRAC_W(FRAC_W), .BIN_CYC(BIN_CYC), .QW(QW)) u_quant (
    .cost_i(cost_arr[free_idx]), .share_i(share),
    .add_i(demand_vec[free_idx]), .q_o(q_now));

  mlp_addr_ram #(.DEPTH(ENTRIES), .DW(ADDR_W)) u_addr (
    .clk(clk), .we(alloc_en), .waddr(alloc_idx), .wdata(alloc_addr),
    .re(hit_free), .raddr(free_idx), .rdata(rel_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid_q <= 1'b0;
      rel_cost_q  <= '0;
    end else begin
      rel_valid_q <= hit_free;
      if (hit_free) rel_cost_q <= q_now;
    end
  end

  assign rel_valid = rel_valid_q;
  assign rel_cost  = rel_cost_q;

  // R5
  release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (free_en && valid_vec[free_idx]) |=> rel_valid);

  // R5
  stray_release_chk: assert property (@(posedge clk) disable iff (rst)
    !(free_en && valid_vec[free_idx]) |=> !rel_valid);

  // R8
  swap_keeps_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (alloc_en && free_en && alloc_idx == free_idx) |=> valid_vec[$past(alloc_idx)]);

  // R3
  demand_share_chk: assert property (@(posedge clk) disable iff (rst)
    (n_demand == CNT_W'(1)) |-> share == SW'(1 << FRAC_W));
endmodule

// File: tb/tb_mlp_cost_acc.sv
module tb_mlp_cost_acc;
  localparam int E = 32;
  localparam int AW = 26;
  localparam int MAXC = (1 << 18) - 1;

  logic clk = 0, rst = 1;
  logic alloc_en = 0, alloc_prefetch = 0, free_en = 0;
  logic [4:0] alloc_idx = 0, free_idx = 0;
  logic [AW-1:0] alloc_addr = 0;
  logic rel_valid;
  logic [AW-1:0] rel_addr;
  logic [2:0] rel_cost;

  always #10 clk = ~clk;

  mlp_cost_acc dut (.clk(clk), .rst(rst), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
    .alloc_addr(alloc_addr), .alloc_prefetch(alloc_prefetch), .free_en(free_en),
    .free_idx(free_idx), .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_cost(rel_cost));

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_valid [E];
  bit m_dem [E];
  int m_cost [E];
  int m_addr [E];
  bit exp_v = 0;
  int exp_addr = 0, exp_cost = 0;

  task automatic compare(input string tag);
    checks++;
    if (rel_valid !== exp_v) begin
      failures++;
      $display("FAIL %s rel_valid=%0b expected %0b", tag, rel_valid, exp_v);
    end else if (exp_v) begin
      checks++;
      if (int'(rel_addr) != exp_addr || int'(rel_cost) != exp_cost) begin
        failures++;
        $display("FAIL %s addr=%0h cost=%0d expected addr=%0h cost=%0d",
                 tag, rel_addr, rel_cost, exp_addr, exp_cost);
      end
    end
  endtask

  task automatic tick(input bit ae, input int ai, input int aa, input bit apf,
                      input bit fe, input int fi, input string tag);
    int n, share, c;
    alloc_en = ae; alloc_idx = 5'(ai); alloc_addr = AW'(aa); alloc_prefetch = apf;
    free_en = fe; free_idx = 5'(fi);
    n = 0;
    for (int i = 0; i < E; i++) if (m_valid[i] && m_dem[i]) n++;
    share = (n == 0) ? 0 : 256 / n;
    exp_v = fe && m_valid[fi];
    if (exp_v) begin
      c = m_dem[fi] ? m_cost[fi] + share : m_cost[fi];
      if (c > MAXC) c = MAXC;
      exp_cost = (c >> 8) / 60;
      if (exp_cost > 7) exp_cost = 7;
      exp_addr = m_addr[fi];
    end
    for (int i = 0; i < E; i++)
      if (m_valid[i] && m_dem[i]) begin
        m_cost[i] += share;
        if (m_cost[i] > MAXC) m_cost[i] = MAXC;
      end
    if (fe) m_valid[fi] = 0;
    if (ae) begin
      m_valid[ai] = 1; m_dem[ai] = !apf; m_cost[ai] = 0; m_addr[ai] = aa;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int cyc, input string tag);
    for (int k = 0; k < cyc; k++) tick(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < E; i++) begin m_valid[i] = 0; m_dem[i] = 0; m_cost[i] = 0; m_addr[i] = 0; end
    repeat (3) @(negedge clk);
    exp_v = 0;
    compare("R1 reset");
    rst = 0;
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 1, i, "R1 release before alloc");
    // R2: 60 charged cycles -> class 1
    tick(1, 0, 'h111, 0, 0, 0, "R2");
    idle(59, "R2");
    tick(0, 0, 0, 0, 1, 0, "R2 sole miss");
    idle(1, "R2");
    // R3: three overlapping demand misses
    tick(1, 1, 'h201, 0, 0, 0, "R3");
    tick(1, 2, 'h202, 0, 0, 0, "R3");
    tick(1, 3, 'h203, 0, 0, 0, "R3");
    idle(200, "R3");
    for (int i = 1; i <= 3; i++) tick(0, 0, 0, 0, 1, i, "R3 shared cost");
    // R4: prefetch beside a demand miss
    tick(1, 4, 'h304, 1, 0, 0, "R4");
    tick(1, 5, 'h305, 0, 0, 0, "R4");
    idle(70, "R4");
    tick(0, 0, 0, 0, 1, 4, "R4 prefetch uncharged");
    tick(0, 0, 0, 0, 1, 5, "R4 demand alone");
    // R6: saturation of class and accumulator
    tick(1, 6, 'h406, 0, 0, 0, "R6");
    idle(1100, "R6");
    tick(0, 0, 0, 0, 1, 6, "R6 saturate");
    // R7: reallocation clears cost
    tick(1, 7, 'h507, 0, 0, 0, "R7");
    idle(200, "R7");
    tick(0, 0, 0, 0, 1, 7, "R7");
    tick(1, 7, 'h517, 0, 0, 0, "R7");
    idle(5, "R7");
    tick(0, 0, 0, 0, 1, 7, "R7 cleared");
    // R8: swap on one slot, and alloc/free on different slots
    tick(1, 8, 'h608, 0, 0, 0, "R8");
    tick(1, 9, 'h609, 0, 0, 0, "R8");
    idle(120, "R8");
    tick(1, 8, 'h618, 0, 1, 8, "R8 swap same slot");
    tick(1, 10, 'h60a, 0, 1, 9, "R8 alloc and free differ");
    idle(65, "R8");
    tick(0, 0, 0, 0, 1, 8, "R8 new miss");
    tick(0, 0, 0, 0, 1, 10, "R8");
    // R5: release of an empty slot
    tick(0, 0, 0, 0, 1, 15, "R5 empty slot");
    tick(0, 0, 0, 0, 1, 8, "R5 double release");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int ai, fi;
      bit ae, fe;
      ai = $urandom_range(0, E - 1);
      fi = $urandom_range(0, E - 1);
      fe = ($urandom_range(0, 9) < 3);
      ae = ($urandom_range(0, 9) < 4) && (!m_valid[ai] || (fe && fi == ai));
      tick(ae, ai, int'($urandom_range(0, 1 << 20)), $urandom_range(0, 3) == 0, fe, fi, "R3 R5 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule